// File: doc/BRIEF.md
# Dual Interval Timer Pair

Two independent 16-bit down-counters sit behind an 8-bit register bus with a 4-bit offset. Each counter has a reload value that software builds one byte at a time, a small control register, and a live count that software reads back byte by byte. A clock-enable input `tick` paces both counters. When a running counter is at zero on a tick, it reloads from its reload value and emits a one-clock underflow pulse towards an external interrupt collector.

Each timer can also show its underflows on a port output bit. In pulse style the bit is high from the underflow until the next tick. In toggle style the bit flips on every underflow. A one-shot mode stops the timer after its first underflow. A load strobe in the control register copies the reload value into the counter at once.

Top module: `dual_interval_timer`

## Requirements
- R1: After a synchronous active-low reset, both reload values and both counts are 0xFFFF. Both control registers read 0x00, and every underflow, port bit and port enable output is low.
- R2: A write to offset 4 (timer 0) or 6 (timer 1) replaces bits 7:0 of that timer's reload value. A write to offset 5 or 7 replaces bits 15:8. The other byte is kept, and the live count does not change.
- R3: A read at offset 4/5 (timer 0) or 6/7 (timer 1) returns the low or high byte of the live count, not the reload value. Unmapped offsets read 0x00.
- R4: Control registers sit at offset 0xE (timer 0) and 0xF (timer 1). Bit 0 is run, bit 1 is port indication enable, bit 2 selects toggle (1) or pulse (0), and bit 3 is one-shot. Bits 7:4 read as zero. Writing bit 4 as 1 copies the reload value into the count in that cycle, and this load takes precedence over a tick in the same cycle.
- R5: While run is set, each cycle with `tick` high decrements the count. A tick with the count at zero instead reloads the count and drives that timer's `uflow` bit high for exactly the next clock cycle, so the underflow period is reload+1 ticks. Without a tick the count holds.
- R6: In one-shot mode the run bit clears at the underflow, and the count then holds the reload value.
- R7: With indication enabled in pulse style, the port bit goes high at the underflow and falls at the next tick.
- R8: With indication enabled in toggle style, the port bit inverts at every underflow. `pbit_oe` follows control bit 1, and `pbit` is low while that bit is clear.
- R9: When a reload-byte write and an underflow fall on the same edge, the reload uses the value held before the write. The new byte takes effect at the following reload.
- R10: The two timers are independent: activity on one leaves the other's count and control unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Count enable, one pulse per counting step |
| bus_addr | input | 4 | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| uflow | output | 2 | Per-timer underflow pulse (bit 0 = timer 0) |
| pbit | output | 2 | Per-timer port indication bit |
| pbit_oe | output | 2 | Per-timer port indication enable |

## Verification
Two collisions are provoked. In the first, a reload-byte write is placed on the very edge where the count underflows. The bench then reads the count during an idle cycle and expects the old reload value; after the next reload it expects the new byte. In the second, a control write carrying the load strobe lands together with a tick while the count is zero. That cycle must load the count with no underflow pulse, and the reference model, which applies the same precedence, is compared against the outputs on every clock.

// File: rtl/dit_pkg.sv
// Shared constants and types for the dual interval timer.
// Assumes an 8-bit data bus and a 4-bit register offset.
package dit_pkg;
    localparam int DATA_W    = 8;
    localparam int OFF_W     = 4;
    localparam int NUM_TMR   = 2;
    localparam int CNT_W     = 2 * DATA_W;
    localparam int CNT_BASE  = 4;    // timer i count/reload bytes at CNT_BASE+2i, +2i+1
    localparam int CTL_BASE  = 14;   // timer i control at CTL_BASE+i
    localparam int CB_LOAD   = 4;    // write-only load strobe bit
    localparam int CTL_KEEP  = 4;    // stored control bits

    // Stored control fields, packed so that bit 0 is run.
    typedef struct packed {
        logic one;
        logic tog;
        logic ind;
        logic run;
    } tctl_t;
endpackage

// File: rtl/dit_decode.sv
// Offset decoder: turns the 4-bit offset into per-timer selects.
// Assumes the register layout held in dit_pkg; outputs are combinational.
module dit_decode
    import dit_pkg::*;
#(
    parameter int N = NUM_TMR
) (
    input  logic [OFF_W-1:0] addr,
    input  logic             wr,
    output logic [N-1:0]     sel_lo,
    output logic [N-1:0]     sel_hi,
    output logic [N-1:0]     sel_ctl,
    output logic [N-1:0]     wr_lo,
    output logic [N-1:0]     wr_hi,
    output logic [N-1:0]     wr_ctl
);
    for (genvar i = 0; i < N; i++) begin : g_dec
        // Match this timer's three offsets and qualify them with the write strobe.
        assign sel_lo[i]  = (addr == OFF_W'(CNT_BASE + 2 * i));
        assign sel_hi[i]  = (addr == OFF_W'(CNT_BASE + 2 * i + 1));
        assign sel_ctl[i] = (addr == OFF_W'(CTL_BASE + i));
        assign wr_lo[i]   = wr & sel_lo[i];
        assign wr_hi[i]   = wr & sel_hi[i];
        assign wr_ctl[i]  = wr & sel_ctl[i];
    end
endmodule

// File: rtl/dit_timer_core.sv
// One 16-bit down-counter with a byte-loaded reload value, control,
// underflow pulse and port indication. Assumes tick is a one-cycle enable.
// Precedence: load strobe over tick; control write over one-shot clear.
module dit_timer_core
    import dit_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic            wr_lo,
    input  logic            wr_hi,
    input  logic            wr_ctl,
    input  logic [DW-1:0]   wdata,
    output logic [2*DW-1:0] count_o,
    output logic [DW-1:0]   ctrl_o,
    output logic            uflow_o,
    output logic            pbit_o,
    output logic            pbit_oe_o
);
    localparam int CW = 2 * DW;

    logic [CW-1:0] latch_q;
    logic [CW-1:0] count_q;
    tctl_t         ctl_q;
    logic          uflow_q;
    logic          pulse_q;
    logic          tog_q;
    logic          force_ld;
    logic          uf_now;

    assign force_ld = wr_ctl & wdata[CB_LOAD];
    assign uf_now   = tick & ctl_q.run & (count_q == '0) & ~force_ld;

    // Reload value: byte-wise replacement from the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_q <= '1;
        end else begin
            if (wr_lo) latch_q[DW-1:0]  <= wdata;
            if (wr_hi) latch_q[CW-1:DW] <= wdata;
        end
    end

    // Live count: forced load, reload on underflow, or decrement on tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '1;
        end else if (force_ld) begin
            count_q <= latch_q;
        end else if (tick && ctl_q.run) begin
            count_q <= (count_q == '0) ? latch_q : count_q - 1'b1;
        end
    end

    // Control fields: bus write wins, otherwise one-shot clears run at underflow.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else if (wr_ctl) begin
            ctl_q <= tctl_t'(wdata[CTL_KEEP-1:0]);
        end else if (uf_now && ctl_q.one) begin
            ctl_q.run <= 1'b0;
        end
    end

    // Underflow pulse and the two port-indication styles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            uflow_q <= 1'b0;
            pulse_q <= 1'b0;
            tog_q   <= 1'b0;
        end else begin
            uflow_q <= uf_now;
            if (uf_now)    pulse_q <= 1'b1;
            else if (tick) pulse_q <= 1'b0;
            if (uf_now)    tog_q   <= ~tog_q;
        end
    end

    assign count_o   = count_q;
    assign ctrl_o    = {{(DW - CTL_KEEP){1'b0}}, ctl_q};
    assign uflow_o   = uflow_q;
    assign pbit_oe_o = ctl_q.ind;
    assign pbit_o    = ctl_q.ind & (ctl_q.tog ? tog_q : pulse_q);
endmodule

// File: rtl/dual_interval_timer.sv
// Two bus-mapped interval timers sharing one tick enable.
// Assumes single-cycle writes; reads are combinational from the offset.
module dual_interval_timer
    import dit_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic [OFF_W-1:0]     bus_addr,
    input  logic                 bus_wr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    output logic [NUM_TMR-1:0]   uflow,
    output logic [NUM_TMR-1:0]   pbit,
    output logic [NUM_TMR-1:0]   pbit_oe
);
    logic [NUM_TMR-1:0]             sel_lo, sel_hi, sel_ctl;
    logic [NUM_TMR-1:0]             wr_lo, wr_hi, wr_ctl;
    logic [NUM_TMR-1:0][CNT_W-1:0]  cnt_w;
    logic [NUM_TMR-1:0][DATA_W-1:0] ctl_w;

    dit_decode #(.N(NUM_TMR)) u_dec (
        .addr   (bus_addr),
        .wr     (bus_wr),
        .sel_lo (sel_lo),
        .sel_hi (sel_hi),
        .sel_ctl(sel_ctl),
        .wr_lo  (wr_lo),
        .wr_hi  (wr_hi),
        .wr_ctl (wr_ctl)
    );

    for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
        dit_timer_core #(.DW(DATA_W)) u_core (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick     (tick),
            .wr_lo    (wr_lo[i]),
            .wr_hi    (wr_hi[i]),
            .wr_ctl   (wr_ctl[i]),
            .wdata    (bus_wdata),
            .count_o  (cnt_w[i]),
            .ctrl_o   (ctl_w[i]),
            .uflow_o  (uflow[i]),
            .pbit_o   (pbit[i]),
            .pbit_oe_o(pbit_oe[i])
        );
    end

    // Read mux: count bytes and control readback; unmapped offsets give zero.
    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NUM_TMR; i++) begin
            if (sel_lo[i])  bus_rdata = cnt_w[i][DATA_W-1:0];
            if (sel_hi[i])  bus_rdata = cnt_w[i][CNT_W-1:DATA_W];
            if (sel_ctl[i]) bus_rdata = ctl_w[i];
        end
    end
endmodule

// File: rtl/dit_chk.sv
// Property checker for dual_interval_timer, attached through bind.
// Observes ports plus the per-timer count and control readback nets.
module dit_chk
    import dit_pkg::*;
(
    input logic                             clk,
    input logic                             rst_n,
    input logic                             tick,
    input logic                             bus_wr,
    input logic [OFF_W-1:0]                 bus_addr,
    input logic [DATA_W-1:0]                bus_rdata,
    input logic [NUM_TMR-1:0]               uflow,
    input logic [NUM_TMR-1:0]               pbit,
    input logic [NUM_TMR-1:0][CNT_W-1:0]    cnt_w,
    input logic [NUM_TMR-1:0][DATA_W-1:0]   ctl_w
);
    // R4
    ctl_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr >= OFF_W'(CTL_BASE)) |-> (bus_rdata[DATA_W-1:CB_LOAD] == '0));

    for (genvar i = 0; i < NUM_TMR; i++) begin : g_chk
        // R5
        uflow_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
            uflow[i] |-> $past(tick));
        // R5
        hold_without_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!tick && !bus_wr) |=> $stable(cnt_w[i]));
        // R6
        oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (uflow[i] && $past(!bus_wr) && ctl_w[i][3]) |-> !ctl_w[i][0]);
        // R7
        pulse_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (uflow[i] && $past(!bus_wr) && ctl_w[i][1] && !ctl_w[i][2]) |-> pbit[i]);
        // R8
        toggle_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (uflow[i] && $past(!bus_wr) && ctl_w[i][1] && ctl_w[i][2])
                |-> (pbit[i] != $past(pbit[i])));
    end
endmodule

bind dual_interval_timer dit_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_rdata(bus_rdata),
    .uflow    (uflow),
    .pbit     (pbit),
    .cnt_w    (cnt_w),
    .ctl_w    (ctl_w)
);

// File: tb/dual_interval_timer_tb_top.sv
// Bench: behavioural reference model compared on every clock, plus directed checks.
module dual_interval_timer_tb_top;
    localparam int CLK_PER = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [3:0] bus_addr = 4'h0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic [1:0] uflow, pbit, pbit_oe;

    int errors = 0;
    int checks = 0;
    int uf0_seen = 0;
    bit mon_on = 1'b0;
    bit done = 1'b0;

    logic [15:0] m_lat [2];
    logic [15:0] m_cnt [2];
    logic        m_run [2], m_ind [2], m_tog [2], m_one [2];
    logic        m_uf [2], m_pq [2], m_tq [2];

    always #(CLK_PER / 2) clk = ~clk;

    dual_interval_timer dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .bus_addr (bus_addr),
        .bus_wr   (bus_wr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .uflow    (uflow),
        .pbit     (pbit),
        .pbit_oe  (pbit_oe)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference model: advances on each rising edge from the bench's own inputs.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 2; i++) begin
                m_lat[i] = 16'hFFFF; m_cnt[i] = 16'hFFFF;
                m_run[i] = 0; m_ind[i] = 0; m_tog[i] = 0; m_one[i] = 0;
                m_uf[i] = 0; m_pq[i] = 0; m_tq[i] = 0;
            end
        end else begin
            for (int i = 0; i < 2; i++) begin
                bit ld, un, cw;
                cw = bus_wr && (int'(bus_addr) == 14 + i);
                ld = cw && bus_wdata[4];
                un = tick && m_run[i] && (m_cnt[i] == 0) && !ld;
                if (ld) m_cnt[i] = m_lat[i];
                else if (tick && m_run[i]) m_cnt[i] = (m_cnt[i] == 0) ? m_lat[i] : m_cnt[i] - 1;
                if (bus_wr && int'(bus_addr) == 4 + 2 * i) m_lat[i][7:0]  = bus_wdata;
                if (bus_wr && int'(bus_addr) == 5 + 2 * i) m_lat[i][15:8] = bus_wdata;
                if (cw) begin
                    m_run[i] = bus_wdata[0]; m_ind[i] = bus_wdata[1];
                    m_tog[i] = bus_wdata[2]; m_one[i] = bus_wdata[3];
                end else if (un && m_one[i]) m_run[i] = 0;
                if (un) m_pq[i] = 1; else if (tick) m_pq[i] = 0;
                if (un) m_tq[i] = !m_tq[i];
                m_uf[i] = un;
            end
        end
    end

    function automatic logic [7:0] exp_rd(input logic [3:0] a);
        case (a)
            4'h4: return m_cnt[0][7:0];
            4'h5: return m_cnt[0][15:8];
            4'h6: return m_cnt[1][7:0];
            4'h7: return m_cnt[1][15:8];
            4'hE: return {4'h0, m_one[0], m_tog[0], m_ind[0], m_run[0]};
            4'hF: return {4'h0, m_one[1], m_tog[1], m_ind[1], m_run[1]};
            default: return 8'h00;
        endcase
    endfunction

    // Per-clock comparison, late in the low phase, before the next rising edge.
    always @(negedge clk) begin
        #(CLK_PER / 2 - 2);
        if (mon_on) begin
            if (bus_addr >= 4'hE) check("R4 control readback", 16'(bus_rdata), 16'(exp_rd(bus_addr)));
            else check("R3 count readback", 16'(bus_rdata), 16'(exp_rd(bus_addr)));
            for (int i = 0; i < 2; i++) begin
                check("R5 underflow pulse", 16'(uflow[i]), 16'(m_uf[i]));
                check("R7 port bit", 16'(pbit[i]),
                      16'(m_ind[i] & (m_tog[i] ? m_tq[i] : m_pq[i])));
                check("R8 port enable", 16'(pbit_oe[i]), 16'(m_ind[i]));
            end
            if (uflow[0]) uf0_seen++;
        end
    end

    task automatic step(input bit t, input bit w, input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        tick = t; bus_wr = w; bus_addr = a; bus_wdata = d;
    endtask

    task automatic peek(input string tag, input logic [3:0] a, input logic [7:0] exp);
        step(0, 0, a, 8'h00);
        #(CLK_PER / 2 - 2);
        check(tag, 16'(bus_rdata), 16'(exp));
    endtask

    initial begin
        #(CLK_PER * 200000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int base;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        mon_on = 1'b1;
        // R1 reset values
        peek("R1 count0 lo", 4'h4, 8'hFF);
        peek("R1 count1 hi", 4'h7, 8'hFF);
        peek("R1 ctrl0", 4'hE, 8'h00);
        check("R1 uflow", 16'(uflow), 16'h0);
        // R2 reload bytes do not reach the count
        step(0, 1, 4'h4, 8'h02);
        step(0, 1, 4'h5, 8'h00);
        peek("R2 count unchanged", 4'h4, 8'hFF);
        peek("R3 unmapped 0", 4'h0, 8'h00);
        peek("R3 unmapped 9", 4'h9, 8'h00);
        // R4 all control bits, upper nibble reads zero, load strobe
        step(0, 1, 4'hE, 8'hF0);
        peek("R4 upper bits zero", 4'hE, 8'h00);
        peek("R4 load strobe", 4'h4, 8'h02);
        // R4 load strobe beats a tick at zero: run, count to 0, then force with tick
        step(0, 1, 4'hE, 8'h01);
        step(1, 0, 4'h4, 8'h00);
        step(1, 0, 4'h4, 8'h00);
        step(1, 1, 4'hE, 8'h11);
        peek("R4 load over tick", 4'h4, 8'h02);
        check("R4 no underflow on load", 16'(uflow[0]), 16'h0);
        // R5 continuous: period reload+1 ticks
        base = uf0_seen;
        for (int k = 0; k < 9; k++) step(1, 0, 4'h4, 8'h00);
        step(0, 0, 4'h4, 8'h00);
        #(CLK_PER / 2);
        check("R5 three underflows in nine ticks", 16'(uf0_seen - base), 16'd3);
        // R9 reload-byte write on the underflow edge (count is 2 here)
        step(1, 0, 4'h4, 8'h00);
        step(1, 0, 4'h4, 8'h00);
        step(1, 1, 4'h4, 8'h07);
        peek("R9 old reload used", 4'h4, 8'h02);
        step(1, 0, 4'h4, 8'h00);
        step(1, 0, 4'h4, 8'h00);
        step(1, 0, 4'h4, 8'h00);
        peek("R9 new reload used", 4'h4, 8'h07);
        // R6 one-shot on timer 1, sparse ticks
        step(0, 1, 4'h6, 8'h03);
        step(0, 1, 4'h7, 8'h00);
        step(0, 1, 4'hF, 8'h19);
        for (int k = 0; k < 12; k++) step(k % 2, 0, 4'hF, 8'h00);
        peek("R6 run cleared", 4'hF, 8'h08);
        peek("R6 count holds reload", 4'h6, 8'h03);
        // R7 pulse style on timer 0, tick every third cycle
        step(0, 1, 4'h4, 8'h01);
        step(0, 1, 4'hE, 8'h13);
        for (int k = 0; k < 24; k++) step(k % 3 == 0, 0, 4'h5, 8'h00);
        // R8 toggle style, then indication disabled
        step(0, 1, 4'hE, 8'h17);
        for (int k = 0; k < 16; k++) step(1, 0, 4'hE, 8'h00);
        step(0, 1, 4'hE, 8'h05);
        peek("R8 oe off", 4'hE, 8'h05);
        check("R8 pbit low when disabled", 16'(pbit[0]), 16'h0);
        for (int k = 0; k < 6; k++) step(1, 0, 4'h4, 8'h00);
        // R10 timer 1 untouched by timer 0 activity
        peek("R10 timer1 count", 4'h6, 8'h03);
        peek("R10 timer1 ctrl", 4'hF, 8'h08);
        step(0, 1, 4'hE, 8'h00);
        step(0, 0, 4'h0, 8'h00);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule